// File: doc/BRIEF.md
# Write-Leveling Early-Delay Resolver

This block sits after the write-leveling trainer of a four-byte-lane DDR data path. It turns each lane's trained DQS delay into the delay the lane actually uses, and into a flag that requests one extra cycle on the command bus. The unit of delay is 1/512 of a clock period. A trained delay close to a full cycle usually means the strobe has to move backwards in time. Each lane compares its delay with a programmable early threshold. If the delay lies above the threshold, the lane either asks for a one-cycle command-bus delay, so that the late strobe appears early relative to the command, or, when its force-zero control is set, drives a strobe delay of zero and asks for nothing.

Trained values arrive on a single-cycle capture strobe together with their period/early adjustment words. Software uses a small synchronous register port to set thresholds and force-zero bits, to override trained delays, to save and restore the adjustment words, and to read per-lane status. The capture strobe has no back-pressure: every strobe is taken in the cycle it is seen. A register write that lands in the same cycle wins for the field it addresses. Control and status pins are plain level signals.

Top module: `wl_early_resolver`

## Requirements
- R1: After reset every strobe delay output, every per-lane command flag and the global command flag are 0, each lane's threshold reads 0x200 with force-zero 0, and every status word reads 0.
- R2: A cycle with `lvl_done_i` high loads each lane's trained delay (`lvl_dly_i` bits [10s+9:10s] for lane s) and sets that lane's status valid bit.
- R3: Outputs are registered one stage after the state: after a capture or a register write at clock edge E, the affected outputs change at edge E+1 and not before.
- R4: A lane is early when its status is valid, its threshold is below 0x200, and its delay is strictly greater than its threshold. An early lane with force-zero 0 drives its own delay and raises its command flag. A delay equal to the threshold is not early.
- R5: A threshold of 0x200 or above disables the lane's early check, whatever its delay, and the lane then outputs its delay unchanged.
- R6: An early lane with force-zero 1 outputs a strobe delay of 0 and keeps its command flag low.
- R7: `cmd_dly_o` is high exactly when at least one lane's command flag is high, and updates in the same cycle as those flags.
- R8: A write to a lane's delay field replaces that lane's delay, sets its valid bit, and drives the outputs like a trained value.
- R9: When a write to a lane's delay or adjust field falls in a capture cycle, that field takes the written value and every other field and lane takes the captured value.
- R10: The adjust field holds the early word in bits [9:0] and the period word in bits [25:16]. It loads from `lvl_adj_i` on capture (per lane 20 bits: early in the low 10 bits, period in the high 10 bits), can be overwritten by a write, and reads back unchanged.
- R11: The register address is lane*4 + field. Field 0 is the delay in bits [9:0]. Field 1 is control, with the threshold in [9:0] and force-zero in bit 16. Field 2 is adjust. Field 3 is the read-only status: bit 0 valid, bit 1 early, bit 2 forced-zero (bits 1 and 2 are the registered early/forced state). Writes to status are ignored, unused bits read 0, and reads take zero wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 4 | Register address (lane*4 + field) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from address |
| lvl_done_i | input | 1 | Single-cycle capture strobe from the trainer |
| lvl_dly_i | input | 40 | Trained delays, 10 bits per lane |
| lvl_adj_i | input | 80 | Trained adjust words, 20 bits per lane |
| dqs_dly_o | output | 40 | Resolved strobe delay, 10 bits per lane |
| cmd_dly_slice_o | output | 4 | Per-lane command-bus delay request |
| cmd_dly_o | output | 1 | Global command-bus one-cycle delay enable |

## Verification
A register write and a capture strobe can fall in the same clock cycle. The bench provokes this by raising `lvl_done_i` while it writes one lane's delay field, and later one lane's adjust field. It judges the result by reading back every lane: the written field must hold the written value, and every other lane and field must hold the captured value. The delay a lane ends up with also drives the early decision one cycle later, so a wrong choice of winner shows up in the per-lane flags as well. A reference model that runs alongside the design compares all outputs and the read data on every clock.

// File: rtl/wl_early_pkg.sv
package wl_early_pkg;
  localparam int DLY_W   = 10;
  localparam int PERIOD  = 512;
  localparam int DATA_W  = 32;
  localparam int FZ_BIT  = 16;
  localparam int PER_LSB = 16;

  typedef enum logic [1:0] {
    FLD_DLY  = 2'd0,
    FLD_CTL  = 2'd1,
    FLD_ADJ  = 2'd2,
    FLD_STAT = 2'd3
  } fld_e;
endpackage

// File: rtl/wl_early_slice.sv
module wl_early_slice
  import wl_early_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_i,
  input  logic [DLY_W-1:0]   cap_dly_i,
  input  logic [2*DLY_W-1:0] cap_adj_i,
  input  logic               wr_dly_i,
  input  logic               wr_ctl_i,
  input  logic               wr_adj_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DLY_W-1:0]   raw_o,
  output logic [DLY_W-1:0]   thr_o,
  output logic               fz_o,
  output logic [2*DLY_W-1:0] adj_o,
  output logic               valid_o,
  output logic [DLY_W-1:0]   dqs_o,
  output logic               cmd_o,
  output logic               cmd_nxt_o,
  output logic               early_o,
  output logic               forced_o
);
  localparam logic [DLY_W-1:0] THR_OFF = DLY_W'(PERIOD);

  logic             early_nxt;
  logic             forced_nxt;
  logic [DLY_W-1:0] dqs_nxt;

  // Stored state: delay, control, adjust, valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_o   <= '0;
      thr_o   <= THR_OFF;
      fz_o    <= 1'b0;
      adj_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      if (wr_dly_i)   raw_o <= wdata_i[DLY_W-1:0];
      else if (cap_i) raw_o <= cap_dly_i;
      if (wr_ctl_i) begin
        thr_o <= wdata_i[DLY_W-1:0];
        fz_o  <= wdata_i[FZ_BIT];
      end
      if (wr_adj_i)   adj_o <= {wdata_i[PER_LSB +: DLY_W], wdata_i[DLY_W-1:0]};
      else if (cap_i) adj_o <= cap_adj_i;
      if (wr_dly_i || cap_i) valid_o <= 1'b1;
    end
  end

  // Early decision
  always_comb begin
    early_nxt  = valid_o && (thr_o < THR_OFF) && (raw_o > thr_o);
    forced_nxt = early_nxt && fz_o;
    cmd_nxt_o  = early_nxt && !fz_o;
    dqs_nxt    = forced_nxt ? '0 : raw_o;
  end

  // Output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqs_o    <= '0;
      cmd_o    <= 1'b0;
      early_o  <= 1'b0;
      forced_o <= 1'b0;
    end else begin
      dqs_o    <= dqs_nxt;
      cmd_o    <= cmd_nxt_o;
      early_o  <= early_nxt;
      forced_o <= forced_nxt;
    end
  end
endmodule

// File: rtl/wl_early_regif.sv
module wl_early_regif
  import wl_early_pkg::*;
#(
  parameter int NSLICE = 4,
  parameter int ADDR_W = 4
) (
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NSLICE*DLY_W-1:0]   raw_i,
  input  logic [NSLICE*DLY_W-1:0]   thr_i,
  input  logic [NSLICE-1:0]         fz_i,
  input  logic [NSLICE*2*DLY_W-1:0] adj_i,
  input  logic [NSLICE-1:0]         valid_i,
  input  logic [NSLICE-1:0]         early_i,
  input  logic [NSLICE-1:0]         forced_i,
  output logic [NSLICE-1:0]         wr_dly_o,
  output logic [NSLICE-1:0]         wr_ctl_o,
  output logic [NSLICE-1:0]         wr_adj_o,
  output logic [DATA_W-1:0]         rdata_o
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] sel;
  fld_e             fld;

  assign sel = addr_i[ADDR_W-1:2];
  assign fld = fld_e'(addr_i[1:0]);

  for (genvar s = 0; s < NSLICE; s++) begin : g_dec
    logic hit;
    assign hit         = wr_en_i && (sel == SEL_W'(s));
    assign wr_dly_o[s] = hit && (fld == FLD_DLY);
    assign wr_ctl_o[s] = hit && (fld == FLD_CTL);
    assign wr_adj_o[s] = hit && (fld == FLD_ADJ);
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NSLICE; s++) begin
      if (sel == SEL_W'(s)) begin
        case (fld)
          FLD_DLY: rdata_o[DLY_W-1:0] = raw_i[s*DLY_W +: DLY_W];
          FLD_CTL: begin
            rdata_o[DLY_W-1:0] = thr_i[s*DLY_W +: DLY_W];
            rdata_o[FZ_BIT]    = fz_i[s];
          end
          FLD_ADJ: begin
            rdata_o[DLY_W-1:0]       = adj_i[s*2*DLY_W +: DLY_W];
            rdata_o[PER_LSB +: DLY_W] = adj_i[s*2*DLY_W+DLY_W +: DLY_W];
          end
          default: rdata_o[2:0] = {forced_i[s], early_i[s], valid_i[s]};
        endcase
      end
    end
  end
endmodule

// File: rtl/wl_early_resolver.sv
module wl_early_resolver
  import wl_early_pkg::*;
#(
  parameter int  NSLICE = 4,
  localparam int ADDR_W = $clog2(NSLICE) + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic                      lvl_done_i,
  input  logic [NSLICE*DLY_W-1:0]   lvl_dly_i,
  input  logic [NSLICE*2*DLY_W-1:0] lvl_adj_i,
  output logic [NSLICE*DLY_W-1:0]   dqs_dly_o,
  output logic [NSLICE-1:0]         cmd_dly_slice_o,
  output logic                      cmd_dly_o
);
  logic [NSLICE*DLY_W-1:0]   raw_flat;
  logic [NSLICE*DLY_W-1:0]   thr_flat;
  logic [NSLICE-1:0]         fz_vec;
  logic [NSLICE*2*DLY_W-1:0] adj_flat;
  logic [NSLICE-1:0]         valid_vec;
  logic [NSLICE-1:0]         early_vec;
  logic [NSLICE-1:0]         forced_vec;
  logic [NSLICE-1:0]         cmd_nxt_vec;
  logic [NSLICE-1:0]         wr_dly;
  logic [NSLICE-1:0]         wr_ctl;
  logic [NSLICE-1:0]         wr_adj;

  wl_early_regif #(.NSLICE(NSLICE), .ADDR_W(ADDR_W)) u_regif (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .raw_i    (raw_flat),
    .thr_i    (thr_flat),
    .fz_i     (fz_vec),
    .adj_i    (adj_flat),
    .valid_i  (valid_vec),
    .early_i  (early_vec),
    .forced_i (forced_vec),
    .wr_dly_o (wr_dly),
    .wr_ctl_o (wr_ctl),
    .wr_adj_o (wr_adj),
    .rdata_o  (rdata_o)
  );

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    wl_early_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (lvl_done_i),
      .cap_dly_i (lvl_dly_i[s*DLY_W +: DLY_W]),
      .cap_adj_i (lvl_adj_i[s*2*DLY_W +: 2*DLY_W]),
      .wr_dly_i  (wr_dly[s]),
      .wr_ctl_i  (wr_ctl[s]),
      .wr_adj_i  (wr_adj[s]),
      .wdata_i   (wdata_i),
      .raw_o     (raw_flat[s*DLY_W +: DLY_W]),
      .thr_o     (thr_flat[s*DLY_W +: DLY_W]),
      .fz_o      (fz_vec[s]),
      .adj_o     (adj_flat[s*2*DLY_W +: 2*DLY_W]),
      .valid_o   (valid_vec[s]),
      .dqs_o     (dqs_dly_o[s*DLY_W +: DLY_W]),
      .cmd_o     (cmd_dly_slice_o[s]),
      .cmd_nxt_o (cmd_nxt_vec[s]),
      .early_o   (early_vec[s]),
      .forced_o  (forced_vec[s])
    );
  end

  // Global request registered alongside the per-lane flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_dly_o <= 1'b0;
    else        cmd_dly_o <= |cmd_nxt_vec;
  end
endmodule

// File: rtl/wl_early_resolver_chk.sv
module wl_early_resolver_chk
  import wl_early_pkg::*;
#(
  parameter int NSLICE = 4,
  parameter int ADDR_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [DATA_W-1:0]       wdata_i,
  input logic                    lvl_done_i,
  input logic [NSLICE*DLY_W-1:0] dqs_dly_o,
  input logic [NSLICE-1:0]       cmd_dly_slice_o,
  input logic                    cmd_dly_o,
  input logic [NSLICE*DLY_W-1:0] raw_flat,
  input logic [NSLICE*DLY_W-1:0] thr_flat,
  input logic [NSLICE-1:0]       fz_vec,
  input logic [NSLICE-1:0]       valid_vec
);
  p_global_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dly_o == (|cmd_dly_slice_o));

  p_capture_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_done_i |=> (&valid_vec));

  for (genvar s = 0; s < NSLICE; s++) begin : g_lane
    // A raised lane flag implies a non-zero strobe delay was kept (R6)
    p_flag_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_dly_slice_o[s] |-> (dqs_dly_o[s*DLY_W +: DLY_W] != '0));

    p_disabled_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_flat[s*DLY_W +: DLY_W] >= DLY_W'(PERIOD)) |=> !cmd_dly_slice_o[s]);

    p_hold_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(raw_flat[s*DLY_W +: DLY_W]) && $stable(thr_flat[s*DLY_W +: DLY_W])
       && $stable(fz_vec[s]) && $stable(valid_vec[s]))
      |=> $stable(dqs_dly_o[s*DLY_W +: DLY_W]));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_done_i && wr_en_i && (addr_i == ADDR_W'(s*4)))
      |=> (raw_flat[s*DLY_W +: DLY_W] == $past(wdata_i[DLY_W-1:0])));
  end
endmodule

bind wl_early_resolver wl_early_resolver_chk #(.NSLICE(NSLICE), .ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_en_i         (wr_en_i),
  .addr_i          (addr_i),
  .wdata_i         (wdata_i),
  .lvl_done_i      (lvl_done_i),
  .dqs_dly_o       (dqs_dly_o),
  .cmd_dly_slice_o (cmd_dly_slice_o),
  .cmd_dly_o       (cmd_dly_o),
  .raw_flat        (raw_flat),
  .thr_flat        (thr_flat),
  .fz_vec          (fz_vec),
  .valid_vec       (valid_vec)
);

// File: tb/tb_wl_early_resolver.sv
module tb_wl_early_resolver;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        lvl_done_i = 1'b0;
  logic [39:0] lvl_dly_i = '0;
  logic [79:0] lvl_adj_i = '0;
  logic [39:0] dqs_dly_o;
  logic [3:0]  cmd_dly_slice_o;
  logic        cmd_dly_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wl_early_resolver dut (.*);

  // Behavioural reference model
  int m_raw[NS], m_thr[NS], m_adj_e[NS], m_adj_p[NS], m_dqs[NS];
  bit m_fz[NS], m_val[NS], m_cmd[NS], m_ear[NS], m_frc[NS];
  bit m_all;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        m_raw[s] <= 0; m_thr[s] <= 512; m_fz[s] <= 0; m_adj_e[s] <= 0; m_adj_p[s] <= 0;
        m_val[s] <= 0; m_dqs[s] <= 0; m_cmd[s] <= 0; m_ear[s] <= 0; m_frc[s] <= 0;
      end
      m_all <= 0;
    end else begin
      bit any;
      any = 0;
      for (int s = 0; s < NS; s++) begin
        bit e;
        bit hit;
        e = m_val[s] && m_thr[s] < 512 && m_raw[s] > m_thr[s];
        m_ear[s] <= e;
        m_frc[s] <= e && m_fz[s];
        m_cmd[s] <= e && !m_fz[s];
        m_dqs[s] <= (e && m_fz[s]) ? 0 : m_raw[s];
        if (e && !m_fz[s]) any = 1;
        hit = wr_en_i && (int'(addr_i) / 4 == s);
        if (hit && addr_i % 4 == 0) begin
          m_raw[s] <= wdata_i[9:0]; m_val[s] <= 1;
        end else if (lvl_done_i) begin
          m_raw[s] <= lvl_dly_i[s*10 +: 10]; m_val[s] <= 1;
        end
        if (hit && addr_i % 4 == 1) begin
          m_thr[s] <= wdata_i[9:0]; m_fz[s] <= wdata_i[16];
        end
        if (hit && addr_i % 4 == 2) begin
          m_adj_e[s] <= wdata_i[9:0]; m_adj_p[s] <= wdata_i[25:16];
        end else if (lvl_done_i) begin
          m_adj_e[s] <= lvl_adj_i[s*20 +: 10]; m_adj_p[s] <= lvl_adj_i[s*20+10 +: 10];
        end
      end
      m_all <= any;
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    int s;
    logic [31:0] r;
    s = int'(a) / 4;
    r = '0;
    case (a % 4)
      0: r[9:0] = m_raw[s][9:0];
      1: begin r[9:0] = m_thr[s][9:0]; r[16] = m_fz[s]; end
      2: begin r[9:0] = m_adj_e[s][9:0]; r[25:16] = m_adj_p[s][9:0]; end
      default: r[2:0] = {m_frc[s], m_ear[s], m_val[s]};
    endcase
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      for (int s = 0; s < NS; s++) begin
        chk(dqs_dly_o[s*10 +: 10] == m_dqs[s][9:0], "R4 lane delay (model)",
            32'(dqs_dly_o[s*10 +: 10]), 32'(m_dqs[s]));
        chk(cmd_dly_slice_o[s] == m_cmd[s], "R4 lane flag (model)",
            32'(cmd_dly_slice_o[s]), 32'(m_cmd[s]));
      end
      chk(cmd_dly_o == m_all, "R7 global flag (model)", 32'(cmd_dly_o), 32'(m_all));
      chk(rdata_o == m_read(addr_i), "R11 read data (model)", rdata_o, m_read(addr_i));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr_i = a;
    #1;
    chk(rdata_o === exp, tag, rdata_o, exp);
  endtask

  task automatic cap(input logic [39:0] d, input logic [79:0] j, input bit with_wr,
                     input logic [3:0] a, input logic [31:0] wd);
    @(negedge clk);
    lvl_done_i = 1; lvl_dly_i = d; lvl_adj_i = j;
    if (with_wr) begin wr_en_i = 1; addr_i = a; wdata_i = wd; end
    @(negedge clk);
    lvl_done_i = 0; wr_en_i = 0;
  endtask

  function automatic logic [79:0] adj_pat(input int base);
    logic [79:0] v;
    for (int s = 0; s < NS; s++) begin
      v[s*20 +: 10]    = 10'(32'h0A0 + base + s);
      v[s*20+10 +: 10] = 10'(32'h100 + base + s);
    end
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(dqs_dly_o == '0, "R1 delays", 32'(dqs_dly_o), 0);
    chk(cmd_dly_slice_o == '0 && cmd_dly_o == 0, "R1 flags", 32'({cmd_dly_slice_o, cmd_dly_o}), 0);
    rd(4'd1, 32'h200, "R1 threshold reset");
    rd(4'd15, 32'h0, "R1 status reset");

    // Program lanes
    wr(4'd1,  32'h1E0);
    wr(4'd5,  32'h200);
    wr(4'd9,  32'h0001_0100);
    wr(4'd13, 32'h180);

    // Capture and R3 timing
    cap({10'h180, 10'h150, 10'h3F0, 10'h1F0}, adj_pat(0), 0, 4'd0, 0);
    chk(dqs_dly_o[9:0] == 10'h000, "R3 output not yet updated", 32'(dqs_dly_o[9:0]), 0);
    @(negedge clk);
    chk(dqs_dly_o[9:0] == 10'h1F0, "R3 output updated next edge", 32'(dqs_dly_o[9:0]), 32'h1F0);
    chk(cmd_dly_slice_o[0] == 1, "R4 early lane flag", 32'(cmd_dly_slice_o[0]), 1);
    chk(cmd_dly_slice_o[3] == 0, "R4 equal not early", 32'(cmd_dly_slice_o[3]), 0);
    chk(cmd_dly_slice_o[1] == 0 && dqs_dly_o[19:10] == 10'h3F0, "R5 disabled threshold",
        32'({cmd_dly_slice_o[1], dqs_dly_o[19:10]}), 32'h3F0);
    chk(dqs_dly_o[29:20] == 0 && cmd_dly_slice_o[2] == 0, "R6 forced zero",
        32'({cmd_dly_slice_o[2], dqs_dly_o[29:20]}), 0);
    chk(cmd_dly_o == 1, "R7 global set", 32'(cmd_dly_o), 1);
    rd(4'd4, 32'h3F0, "R2 captured delay");
    rd(4'd3, 32'h3, "R2 status valid and early");
    rd(4'd11, 32'h7, "R6 R11 forced status");
    rd(4'd6, 32'h0101_00A1, "R10 captured adjust");

    // R8 override
    wr(4'd0, 32'h010);
    @(negedge clk);
    chk(cmd_dly_o == 0 && dqs_dly_o[9:0] == 10'h010, "R8 override clears flag",
        32'({cmd_dly_o, dqs_dly_o[9:0]}), 32'h010);

    // R9 collision: write lane 3 delay during capture
    cap({10'h300, 10'h020, 10'h050, 10'h1E1}, adj_pat(8), 1, 4'd12, 32'h07F);
    rd(4'd12, 32'h07F, "R9 written lane keeps write");
    rd(4'd0, 32'h1E1, "R9 other lane captured");
    chk(cmd_dly_slice_o[0] == 1 && cmd_dly_slice_o[3] == 0, "R4 R9 boundary 0x1E1 early",
        32'(cmd_dly_slice_o), 32'h1);

    // Boundary: delay equal to threshold
    wr(4'd0, 32'h1E0);
    @(negedge clk);
    chk(cmd_dly_slice_o[0] == 0, "R4 delay equal threshold", 32'(cmd_dly_slice_o[0]), 0);

    // R5 threshold above one period
    wr(4'd1, 32'h250);
    wr(4'd0, 32'h300);
    @(negedge clk);
    chk(cmd_dly_slice_o[0] == 0 && dqs_dly_o[9:0] == 10'h300, "R5 threshold above period",
        32'({cmd_dly_slice_o[0], dqs_dly_o[9:0]}), 32'h300);

    // R10 adjust write, then collision on adjust
    wr(4'd10, 32'h00AA_0055);
    rd(4'd10, 32'h00AA_0055, "R10 adjust written");
    cap({10'h001, 10'h002, 10'h003, 10'h004}, adj_pat(16), 1, 4'd10, 32'h0033_0022);
    rd(4'd10, 32'h0033_0022, "R9 R10 adjust write wins");
    rd(4'd14, 32'h0113_00B3, "R10 other lane adjust captured");

    // R11 write to status ignored
    wr(4'd3, 32'h0);
    rd(4'd3, 32'h1, "R11 status write ignored");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule